// File: doc/BRIEF.md
# Mode-Selectable Memory ECC Controller

This block sits between one requesting agent and a memory array whose words carry 64 data bits and 8 check bits. A 2-bit configuration field picks one of three integrity modes at run time. With protection off, the block passes requests through. Reads come back with no checking, and sub-word writes go to memory as byte-masked writes with no added cycles. In the two protected modes, every write to memory carries check bits computed over the whole 64-bit word, and every read is checked against the stored check bits. Check-only mode reports errors but returns the raw data. Correcting mode also repairs single-bit errors in the returned data.

When protection is on, a write whose byte enables are not all set cannot update the stored check bits directly. The block fetches the target word, merges the enabled new bytes into it, and writes back the full word with fresh check bits. While this runs, the requester is held off. The memory side is a simple synchronous request/response port with in-order read returns. Two sticky status flags record single-bit and multi-bit errors until the requester clears them.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: After reset, `cfg_mode` reads 00 (unprotected), both status flags are clear, `req_ready` is high and `rsp_valid` is low.
- R2: A cycle with `cfg_we` high loads `cfg_mode_wr` into the mode field, which reads back on `cfg_mode`. The encoding is 00 unprotected, 01 check-only, 10 check-and-correct, and 11 reserved. The reserved value behaves exactly like check-only: errors are flagged and the data is not corrected.
- R3: In mode 00, a write is issued to memory in the cycle it is accepted, with `mem_wbe` equal to `req_be` and `mem_wcheck_en` low, so the stored check bits stay unchanged. `req_ready` stays high. Reads are not checked and never raise `rsp_sbe`, `rsp_mbe` or the status flags.
- R4: In a protected mode, every memory write has `mem_wbe` = 8'hFF and `mem_wcheck_en` high. The check bits are formed as follows. Bit i (i = 0..6) is the XOR of the data bits whose code position has bit i set. Data bit d takes code position d-th in ascending order among the values 1..71 that are not powers of two, so data bit 0 sits at position 3. Bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R5: In check-only mode, a read with one flipped bit returns the stored data unmodified and raises `rsp_sbe`.
- R6: In check-and-correct mode, a read with any single flipped bit among the 72 returns the original data and raises `rsp_sbe` but not `rsp_mbe`.
- R7: In a protected mode, a read with two flipped bits raises `rsp_mbe` and not `rsp_sbe`, and returns the data uncorrected.
- R8: In a protected mode, a write with any byte enable low is carried out as a read of the target word followed by a full-word write-back of the merged data with fresh check bits. `req_ready` is low for exactly two cycles after acceptance.
- R9: `sts_sbe` and `sts_mbe` are set by a detected error on any read in a protected mode, including the read inside a read-merge-write. They hold until `sts_clr` is pulsed, and a new error in the clearing cycle wins over the clear.
- R10: `rsp_valid` and the response data appear in the same cycle as `mem_rvalid` in every mode, with no added checking delay.
- R11: A read-merge-write in check-and-correct mode merges into the corrected old word. In check-only mode it merges into the raw old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load the mode field |
| cfg_mode_wr | input | 2 | New mode value |
| cfg_mode | output | 2 | Current mode field |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for the write |
| rsp_valid | output | 1 | Read data returned |
| rsp_rdata | output | 64 | Returned read data |
| rsp_sbe | output | 1 | This response had a single-bit error |
| rsp_mbe | output | 1 | This response had a multi-bit error |
| sts_clr | input | 1 | Clear both sticky status flags |
| sts_sbe | output | 1 | Sticky single-bit error flag |
| sts_mbe | output | 1 | Sticky multi-bit error flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_wbe | output | 8 | Memory byte write mask |
| mem_wcheck | output | 8 | Check bits to store |
| mem_wcheck_en | output | 1 | Store `mem_wcheck` with this write |
| mem_rvalid | input | 1 | Memory read data valid (in order) |
| mem_rdata | input | 64 | Memory read data |
| mem_rcheck | input | 8 | Stored check bits read back |

## Verification
The hardest cases to reach from the ports are stored words that are no longer valid codewords. A correct requester never writes such words, so a single- or double-bit error inside a read-merge-write cannot arise through the normal interface. The bench owns the memory model, so it flips chosen bits of a stored word directly. It then sweeps every one of the 72 single-bit positions and a spread of bit pairs through each protected mode. It also runs partial writes over words that already hold a flipped bit, to show whether the corrected or the raw old bytes are merged. Every byte-enable pattern is also swept in unprotected and check-only mode, with the expected merged words and check bits computed arithmetically.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DW   = 64;
  localparam int CW   = 8;
  localparam int HB   = 7;
  localparam int NPOS = 71;
  localparam int NBYTE = DW / 8;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_DETECT = 2'b01,
    MODE_FIX    = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FETCH,
    SEQ_WBACK
  } seq_e;

  // Code position of data bit d: d-th non-power-of-two value in 1..NPOS.
  function automatic int data_pos(int d);
    int k;
    int res;
    k = 0;
    res = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == d) res = p;
        k++;
      end
    end
    return res;
  endfunction

  // Data bits covered by Hamming bit b.
  function automatic logic [DW-1:0] cover_mask(int b);
    logic [DW-1:0] m;
    m = '0;
    for (int d = 0; d < DW; d++) begin
      if (((data_pos(d) >> b) & 1) == 1) m[d] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
  import ecc_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] check
);
  logic [HB-1:0] hbits;

  for (genvar g = 0; g < HB; g++) begin : g_hbit
    localparam logic [DW-1:0] MASK = cover_mask(g);
    assign hbits[g] = ^(data & MASK);
  end

  assign check = {(^data) ^ (^hbits), hbits};
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
  import ecc_pkg::*;
(
  input  logic [DW-1:0] rdata,
  input  logic [CW-1:0] rcheck,
  output logic [DW-1:0] corr,
  output logic          single_err,
  output logic          multi_err
);
  logic [CW-1:0] recomp;
  logic [HB-1:0] syn;
  logic          odd;
  logic [DW-1:0] flip;

  ecc_encode u_reenc (.data(rdata), .check(recomp));

  assign syn = rcheck[HB-1:0] ^ recomp[HB-1:0];
  // Overall parity of the received 72 bits.
  assign odd = rcheck[CW-1] ^ recomp[CW-1] ^ (^syn);

  assign single_err = odd;
  assign multi_err  = !odd && (syn != '0);

  for (genvar g = 0; g < DW; g++) begin : g_fix
    localparam logic [HB-1:0] POS = HB'(data_pos(g));
    assign flip[g] = odd && (syn == POS);
  end

  assign corr = rdata ^ flip;
endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PEND_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [NBYTE-1:0] req_be,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    old_word,
  output logic             host_rsp,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [NBYTE-1:0] mem_wbe
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  seq_e              state_q, state_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, merged_q, merged_d;
  logic [NBYTE-1:0]  be_q;
  logic              accept, rmw_go, host_rd, rmw_rsp, pend_en;

  assign req_ready = (state_q == SEQ_IDLE) && (pend_q != PEND_MAX);
  assign accept    = req_valid && req_ready;
  assign rmw_go    = accept && req_write && prot && (req_be != '1);
  assign host_rd   = accept && !req_write;
  assign host_rsp  = mem_rvalid && (pend_q != '0);
  assign rmw_rsp   = mem_rvalid && (pend_q == '0) && (state_q == SEQ_FETCH);
  assign pend_en   = host_rd || host_rsp;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE:  if (rmw_go)  state_d = SEQ_FETCH;
      SEQ_FETCH: if (rmw_rsp) state_d = SEQ_WBACK;
      SEQ_WBACK: state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (host_rd && !host_rsp)      pend_d = pend_q + 1'b1;
    else if (!host_rd && host_rsp) pend_d = pend_q - 1'b1;
  end

  always_comb begin
    for (int b = 0; b < NBYTE; b++) begin
      merged_d[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : old_word[8*b +: 8];
    end
  end

  always_comb begin
    mem_req   = accept || (state_q == SEQ_WBACK);
    mem_we    = (state_q == SEQ_WBACK) || (accept && req_write && !rmw_go);
    mem_addr  = (state_q == SEQ_WBACK) ? addr_q : req_addr;
    mem_wdata = (state_q == SEQ_WBACK) ? merged_q : req_wdata;
    mem_wbe   = ((state_q == SEQ_WBACK) || prot) ? '1 : req_be;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rmw_go) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
    if (rmw_rsp) merged_q <= merged_d;
  end
endmodule

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
  import ecc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PEND_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode_wr,
  output logic [1:0]    cfg_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  input  logic [7:0]    req_be,
  output logic          rsp_valid,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_sbe,
  output logic          rsp_mbe,
  input  logic          sts_clr,
  output logic          sts_sbe,
  output logic          sts_mbe,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic [7:0]    mem_wbe,
  output logic [7:0]    mem_wcheck,
  output logic          mem_wcheck_en,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  input  logic [7:0]    mem_rcheck
);
  logic          rst_meta, rst_s;
  mode_e         mode_q, mode_d;
  logic          prot, fix;
  logic [CW-1:0] gen_chk;
  logic [DW-1:0] corr, data_out;
  logic          d_sbe, d_mbe, host_rsp, err_s, err_m;
  logic          sbe_q, sbe_d, mbe_q, mbe_d, sts_en;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  assign mode_d = mode_e'(cfg_mode_wr);
  assign prot   = (mode_q != MODE_OFF);
  assign fix    = (mode_q == MODE_FIX);

  ecc_rmw_seq #(.AW(AW), .PEND_W(PEND_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .prot      (prot),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .mem_rvalid(mem_rvalid),
    .old_word  (data_out),
    .host_rsp  (host_rsp),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wbe   (mem_wbe)
  );

  ecc_encode u_enc (.data(mem_wdata), .check(gen_chk));

  ecc_decode u_dec (
    .rdata     (mem_rdata),
    .rcheck    (mem_rcheck),
    .corr      (corr),
    .single_err(d_sbe),
    .multi_err (d_mbe)
  );

  assign mem_wcheck    = prot ? gen_chk : '0;
  assign mem_wcheck_en = prot;

  assign data_out  = fix ? corr : mem_rdata;
  assign rsp_valid = host_rsp;
  assign rsp_rdata = data_out;
  assign rsp_sbe   = host_rsp && prot && d_sbe;
  assign rsp_mbe   = host_rsp && prot && d_mbe;

  assign err_s  = mem_rvalid && prot && d_sbe;
  assign err_m  = mem_rvalid && prot && d_mbe;
  assign sbe_d  = err_s || (sbe_q && !sts_clr);
  assign mbe_d  = err_m || (mbe_q && !sts_clr);
  assign sts_en = err_s || err_m || sts_clr;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mode_q <= MODE_OFF;
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
    end else begin
      if (cfg_we) mode_q <= mode_d;
      if (sts_en) begin
        sbe_q <= sbe_d;
        mbe_q <= mbe_d;
      end
    end
  end

  assign cfg_mode = mode_q;
  assign sts_sbe  = sbe_q;
  assign sts_mbe  = mbe_q;
endmodule

// File: rtl/ecc_mem_ctrl_chk.sv
module ecc_mem_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_mode,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [7:0]  req_be,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata,
  input logic        rsp_sbe,
  input logic        rsp_mbe,
  input logic        sts_clr,
  input logic        sts_sbe,
  input logic        sts_mbe,
  input logic        mem_req,
  input logic        mem_we,
  input logic [7:0]  mem_wbe,
  input logic        mem_rvalid,
  input logic [63:0] mem_rdata
);
  AST_UNPROT_MASK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && cfg_mode == 2'b00) |-> (mem_req && mem_we && mem_wbe == req_be)); // R3
  AST_PROT_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && cfg_mode != 2'b00) |-> (mem_wbe == 8'hFF)); // R4
  AST_RMW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && cfg_mode != 2'b00 && req_be != 8'hFF) |=> !req_ready); // R8
  AST_DETECT_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cfg_mode == 2'b01) |-> (rsp_rdata == mem_rdata)); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_sbe && rsp_mbe)); // R7
  AST_SBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_sbe && !sts_clr) |=> sts_sbe); // R9
  AST_MBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_mbe && !sts_clr) |=> sts_mbe); // R9
  AST_RSP_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_rvalid); // R10
endmodule

bind ecc_mem_ctrl ecc_mem_ctrl_chk u_chk (.*);

// File: tb/tb_ecc_mem_ctrl.sv
module tb_ecc_mem_ctrl;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_mode_wr = 2'b00;
  logic [1:0]    cfg_mode;
  logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic [7:0]    req_be = '0;
  logic          rsp_valid, rsp_sbe, rsp_mbe;
  logic [63:0]   rsp_rdata;
  logic          sts_clr = 1'b0, sts_sbe, sts_mbe;
  logic          mem_req, mem_we, mem_wcheck_en;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic [7:0]    mem_wbe, mem_wcheck;
  logic          mem_rvalid = 1'b0;
  logic [63:0]   mem_rdata = '0;
  logic [7:0]    mem_rcheck = '0;

  logic [71:0] store [16];
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_mem_ctrl #(.AW(AW)) dut (.*);

  // Memory model: one-cycle read latency, byte-masked writes.
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && !mem_we) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= store[mem_addr][63:0];
      mem_rcheck <= store[mem_addr][71:64];
    end
    if (mem_req && mem_we) begin
      for (int b = 0; b < 8; b++)
        if (mem_wbe[b]) store[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (mem_wcheck_en) store[mem_addr][71:64] <= mem_wcheck;
    end
  end

  // Reference code: XOR the code positions of all set data bits.
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] acc;
    int k;
    acc = '0;
    k = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) acc = acc ^ 7'(p);
        k++;
      end
    end
    return {(^d) ^ (^acc), acc};
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_mode_wr = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be, output int stall);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    stall = 0;
    while (!req_ready && stall < 20) begin
      stall++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [63:0] d, output logic s, output logic m, output logic v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    v = rsp_valid; d = rsp_rdata; s = rsp_sbe; m = rsp_mbe;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_sim();
  end

  initial begin
    logic [63:0] d, oldd, newd, exp;
    logic s, m, v;
    int stall;
    logic [1:0] mlist [3];

    for (int i = 0; i < 16; i++) store[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cfg_mode == 2'b00, "R1 mode", 72'(cfg_mode), 72'd0);
    check(!sts_sbe && !sts_mbe, "R1 flags", {sts_sbe, sts_mbe}, 72'd0);
    check(req_ready && !rsp_valid, "R1 ready", {req_ready, rsp_valid}, 72'd2);

    // R2 mode readback
    for (int i = 3; i >= 0; i--) begin
      set_mode(2'(i));
      check(cfg_mode == 2'(i), "R2 readback", 72'(cfg_mode), 72'(i));
    end

    // R3 / R4 / R8: byte-enable sweep, unprotected then check-only
    for (int md = 0; md < 2; md++) begin
      set_mode(2'(md));
      for (int be = 0; be < 256; be++) begin
        logic [AW-1:0] a;
        a = AW'(be);
        oldd = 64'h0123_4567_89AB_CDEF ^ {8{8'(be)}};
        newd = {oldd[31:0], oldd[63:32]} ^ 64'hF0F0_3C3C_A5A5_0FF0;
        store[a] = (md == 0) ? {8'hA5, oldd} : {ref_chk(oldd), oldd};
        do_write(a, newd, 8'(be), stall);
        exp = merge(oldd, newd, 8'(be));
        if (md == 0) begin
          check(store[a] == {8'hA5, exp}, "R3 masked store", store[a], {8'hA5, exp});
          check(stall == 0, "R3 no stall", 72'(stall), 72'd0);
        end else if (be == 255) begin
          check(store[a] == {ref_chk(newd), newd}, "R4 full write", store[a], {ref_chk(newd), newd});
          check(stall == 0, "R4 no stall", 72'(stall), 72'd0);
        end else begin
          check(store[a] == {ref_chk(exp), exp}, "R8 merged store", store[a], {ref_chk(exp), exp});
          check(stall == 2, "R8 stall cycles", 72'(stall), 72'd2);
        end
      end
    end

    // R3 unprotected read with corrupt check bits
    set_mode(2'b00);
    pulse_clr();
    store[3] = {8'h00, 64'hDEAD_BEEF_0000_0001};
    do_read(4'd3, d, s, m, v);
    check(v, "R10 rsp timing off", 72'(v), 72'd1);
    check(d == 64'hDEAD_BEEF_0000_0001 && !s && !m, "R3 unchecked read", {s, m, d}, {2'b00, 64'hDEAD_BEEF_0000_0001});
    @(negedge clk);
    check(!sts_sbe && !sts_mbe, "R3 no flags", {sts_sbe, sts_mbe}, 72'd0);

    // R6 / R5 / R2: single-bit sweep in modes 10, 01, 11
    mlist[0] = 2'b10; mlist[1] = 2'b01; mlist[2] = 2'b11;
    for (int mi = 0; mi < 3; mi++) begin
      set_mode(mlist[mi]);
      for (int k = 0; k < 72; k++) begin
        logic [71:0] bad;
        oldd = 64'h5A5A_1234_F00D_C0DE ^ (64'(k) * 64'h0101_0101_0101_0101);
        bad = {ref_chk(oldd), oldd} ^ (72'd1 << k);
        store[5] = bad;
        do_read(4'd5, d, s, m, v);
        check(v, "R10 rsp timing prot", 72'(v), 72'd1);
        if (mi == 0) begin
          check(d == oldd && s && !m, "R6 single corrected", {s, m, d}, {2'b10, oldd});
        end else if (mi == 1) begin
          check(d == bad[63:0] && s && !m, "R5 detect raw", {s, m, d}, {2'b10, bad[63:0]});
        end else begin
          check(d == bad[63:0] && s && !m, "R2 reserved as detect", {s, m, d}, {2'b10, bad[63:0]});
        end
      end
    end

    // R7 double-bit sweep in correcting mode
    set_mode(2'b10);
    for (int k = 0; k < 72; k++) begin
      logic [71:0] bad;
      int j;
      j = (k + 1 + (k % 13)) % 72;
      oldd = 64'hC3C3_9999_0F0F_7777 ^ (64'(k) << 7);
      bad = {ref_chk(oldd), oldd} ^ (72'd1 << k) ^ (72'd1 << j);
      store[6] = bad;
      do_read(4'd6, d, s, m, v);
      check(d == bad[63:0] && !s && m, "R7 double detect", {s, m, d}, {2'b01, bad[63:0]});
    end

    // R9 sticky flags
    pulse_clr();
    @(negedge clk);
    check(!sts_sbe && !sts_mbe, "R9 cleared", {sts_sbe, sts_mbe}, 72'd0);
    oldd = 64'h1111_2222_3333_4444;
    store[8] = {ref_chk(oldd), oldd} ^ (72'd1 << 9);
    store[9] = {ref_chk(oldd), oldd};
    store[10] = {ref_chk(oldd), oldd} ^ 72'h3;
    do_read(4'd8, d, s, m, v);
    @(negedge clk);
    check(sts_sbe && !sts_mbe, "R9 sbe set", {sts_sbe, sts_mbe}, 72'd2);
    do_read(4'd9, d, s, m, v);
    @(negedge clk);
    check(sts_sbe && !sts_mbe, "R9 sbe held", {sts_sbe, sts_mbe}, 72'd2);
    do_read(4'd10, d, s, m, v);
    @(negedge clk);
    check(sts_sbe && sts_mbe, "R9 both set", {sts_sbe, sts_mbe}, 72'd3);
    pulse_clr();
    check(!sts_sbe && !sts_mbe, "R9 clear", {sts_sbe, sts_mbe}, 72'd0);

    // R11 merge source in read-merge-write
    for (int mi = 0; mi < 2; mi++) begin
      logic [71:0] bad;
      set_mode(mi == 0 ? 2'b10 : 2'b01);
      pulse_clr();
      oldd = 64'hAAAA_BBBB_CCCC_DDDD;
      newd = 64'h1234_5678_9ABC_DEF0;
      bad = {ref_chk(oldd), oldd} ^ (72'd1 << 3);
      store[12] = bad;
      do_write(4'd12, newd, 8'hF0, stall);
      exp = merge(mi == 0 ? oldd : bad[63:0], newd, 8'hF0);
      check(store[12] == {ref_chk(exp), exp}, "R11 merge source", store[12], {ref_chk(exp), exp});
      check(sts_sbe, "R9 rmw read flags", 72'(sts_sbe), 72'd1);
    end

    finish_sim();
  end
endmodule